// File: doc/BRIEF.md
# Multiplexed 8/16-Bit External Bus Controller

This block runs external memory cycles on a shared address/data bus. A core-side port hands it one request at a time: a read, a write or an instruction fetch, sized as a byte or a 16-bit word. The controller then sequences the bus cycle. First comes an address phase, in which the address is driven on the shared lines. Then comes a data phase, in which the read strobe or the write strobes are active. The cycle closes with an end phase. A single clock of `req_done` hands read data back to the core.

The width of each cycle is chosen while the cycle runs. When dynamic sizing is enabled, the `bus_width_in` pin is sampled at the end of the address phase: high gives a 16-bit cycle and low gives an 8-bit cycle. With dynamic sizing off, every cycle is 8-bit. A word request that lands on an 8-bit cycle becomes two byte cycles, even address first, and the two bytes are reassembled into one word for the core.

Two output pins have selectable roles:
- The address strobe works either as a latch pulse or as a cycle-long, active-low valid signal.
- One pin pair carries either a combined write strobe with a byte-high enable, or separate low-byte and high-byte write strobes.

The `ready_in` pin stretches the data phase by wait states, up to a configured cap. A hold/acknowledge handshake lets an external master take the bus between cycles.

The core holds `req_valid` and the request fields until it sees `req_done`. It drops or replaces them on the following clock.

Top module: `ext_bus_ctl`

## Requirements
- R1: With `cfg_dyn_width`=1, a `bus_width_in` of 1 sampled in the address phase gives a single 16-bit cycle for a word request. A `bus_width_in` of 0, or `cfg_dyn_width`=0, gives 8-bit cycles.
- R2: With `cfg_split_wr`=0, `bhe_wrh_n` is a byte-high enable. It reads 0 when the high byte is transferred: an odd byte, or the first cycle of a word. It reads 1 for an even byte alone. `ad_out[0]` carries address bit 0 during the address phase.
- R3: A word request on an 8-bit cycle runs two cycles: the first at the even address, the second at the even address plus one. The read result is {second byte, first byte}.
- R4: With `cfg_split_wr`=1, `wr_lo_n` is low only in write data phases that have address bit 0 = 0. `bhe_wrh_n` is low only in write data phases at an odd address, or in a 16-bit word write. With `cfg_split_wr`=0, `wr_lo_n` is low in every write data phase. No write strobe is ever low together with `rd_n`.
- R5: `addr_strobe` is high after reset, while idle, and in the end phase, and low in every data phase. In the address phase it is 1 when `cfg_valid_mode`=0 (latch pulse) and 0 when `cfg_valid_mode`=1 (valid signal).
- R6: Each data-phase clock ending with `ready_in`=0 adds one wait state, up to `cfg_wait_max`. A half-cycle therefore lasts 1+min(ready-low clocks, `cfg_wait_max`) data clocks.
- R7: `inst` is 1 through the address and data phases of a fetch read, and 0 otherwise.
- R8: With `cfg_hold_en`=1 and `hold_in`=1, the bus is granted only from idle, never inside or between the halves of a request. While granted, `hold_ack`=1 and `ad_oe`=`ctl_oe`=0. With `cfg_hold_en`=0, `hold_in` has no effect.
- R9: `bus_req` is 1 while `hold_ack`=1 and `req_valid`=1, and 0 otherwise.
- R10: After reset: `addr_strobe`, `rd_n`, `wr_lo_n` and `bhe_wrh_n` are all 1; `ad_oe`, `inst`, `hold_ack` and `req_done` are all 0.
- R11: Read bytes come from `ad_in[15:8]` in a 16-bit cycle at an odd address, and from `ad_in[7:0]` otherwise. A byte write drives the byte on both lanes. Byte reads return the byte zero-extended.
- R12: `req_done` is a single-clock pulse in the end phase of the last cycle of a request, with `req_rdata` valid in that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request pending |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fetch | input | 1 | Read is an instruction fetch |
| req_word | input | 1 | 1 = 16-bit access (address bit 0 ignored), 0 = byte |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 16 | Write data; a byte write uses bits 7:0 |
| req_done | output | 1 | Request finished pulse |
| req_rdata | output | 16 | Read result |
| cfg_dyn_width | input | 1 | Enable per-cycle width from `bus_width_in` |
| cfg_valid_mode | input | 1 | Address strobe acts as a valid signal |
| cfg_split_wr | input | 1 | Separate low/high write strobes |
| cfg_wait_max | input | WAIT_W | Maximum wait states per cycle |
| cfg_hold_en | input | 1 | Enable hold/acknowledge |
| bus_width_in | input | 1 | Width select, 1 = 16-bit |
| ready_in | input | 1 | Ready, 0 = insert wait |
| ad_in | input | 16 | Bus read data |
| ad_out | output | 16 | Bus address/write data |
| ad_oe | output | 1 | Bus output enable |
| ctl_oe | output | 1 | Control pin output enable |
| addr_strobe | output | 1 | Address latch strobe or valid (low) |
| rd_n | output | 1 | Read strobe |
| wr_lo_n | output | 1 | Write strobe or low-byte write strobe |
| bhe_wrh_n | output | 1 | Byte-high enable or high-byte write strobe |
| inst | output | 1 | Fetch indicator |
| hold_in | input | 1 | External master requests bus |
| hold_ack | output | 1 | Bus granted |
| bus_req | output | 1 | Cycle pending while granted |

## Verification
A sweep crosses dynamic sizing, the width pin, both pin-role selections and both strobe modes. Each point of the sweep runs byte reads at even and odd addresses, word reads, and byte and word writes. This separates single 16-bit cycles from split pairs and upper-lane reads from lower-lane reads. Writes land in a byte-wide model memory, so a lane or strobe error shows up as a wrong or clobbered neighbouring byte. A second sweep runs ready-low counts against several wait caps, which shows whether the cap binds. Hold requests are raised while the block is disabled, while it is idle with work pending, and in the middle of a split word, which separates the grant-at-boundary rule from an immediate grant.

// File: rtl/ext_bus_ctl.sv
module ext_bus_ctl #(
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_fetch,
  input  logic              req_word,
  input  logic [15:0]       req_addr,
  input  logic [15:0]       req_wdata,
  output logic              req_done,
  output logic [15:0]       req_rdata,
  input  logic              cfg_dyn_width,
  input  logic              cfg_valid_mode,
  input  logic              cfg_split_wr,
  input  logic [WAIT_W-1:0] cfg_wait_max,
  input  logic              cfg_hold_en,
  input  logic              bus_width_in,
  input  logic              ready_in,
  input  logic [15:0]       ad_in,
  output logic [15:0]       ad_out,
  output logic              ad_oe,
  output logic              ctl_oe,
  output logic              addr_strobe,
  output logic              rd_n,
  output logic              wr_lo_n,
  output logic              bhe_wrh_n,
  output logic              inst,
  input  logic              hold_in,
  output logic              hold_ack,
  output logic              bus_req
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_DATA, S_END, S_HELD} state_t;

  state_t            state;
  logic              r_write, r_fetch, r_word, r_second, r_w16, r_more;
  logic [15:0]       r_addr, r_wdata, rdata;
  logic [WAIT_W-1:0] wcnt;

  logic       cur_a0, in_cycle, finish, hold_req, wr_any, wr_hi;
  logic [7:0] lane, wbyte;

  assign hold_req = cfg_hold_en & hold_in;
  assign cur_a0   = r_word ? r_second : r_addr[0];
  assign in_cycle = (state == S_ADDR) || (state == S_DATA);
  assign lane     = (r_w16 && cur_a0) ? ad_in[15:8] : ad_in[7:0];
  assign finish   = (state == S_DATA) && (ready_in || (wcnt >= cfg_wait_max));
  assign wbyte    = r_word ? r_wdata[15:8] : r_wdata[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      r_write  <= 1'b0;
      r_fetch  <= 1'b0;
      r_word   <= 1'b0;
      r_second <= 1'b0;
      r_w16    <= 1'b0;
      r_more   <= 1'b0;
      r_addr   <= '0;
      r_wdata  <= '0;
      rdata    <= '0;
      wcnt     <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (hold_req) begin
            state <= S_HELD;
          end else if (req_valid) begin
            r_write  <= req_write;
            r_fetch  <= req_fetch;
            r_word   <= req_word;
            r_addr   <= req_addr;
            r_wdata  <= req_wdata;
            r_second <= 1'b0;
            r_more   <= 1'b0;
            state    <= S_ADDR;
          end
        end
        S_HELD: if (!hold_req) state <= S_IDLE;
        S_ADDR: begin
          r_w16 <= cfg_dyn_width & bus_width_in;
          wcnt  <= '0;
          state <= S_DATA;
        end
        S_DATA: begin
          if (finish) begin
            if (!r_write) begin
              if (!r_word)        rdata <= {8'h00, lane};
              else if (!r_second) rdata <= r_w16 ? ad_in : {8'h00, ad_in[7:0]};
              else                rdata[15:8] <= lane;
            end
            r_more <= r_word & ~r_second & ~r_w16;
            state  <= S_END;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        S_END: begin
          if (r_more) begin
            r_second <= 1'b1;
            r_more   <= 1'b0;
            state    <= S_ADDR;
          end else begin
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign wr_any = (state == S_DATA) && r_write;
  assign wr_hi  = wr_any && (cur_a0 || (r_word && !r_second && r_w16));

  assign req_done    = (state == S_END) && !r_more;
  assign req_rdata   = rdata;
  assign ad_oe       = (state == S_ADDR) || wr_any;
  assign ad_out      = (state == S_ADDR) ? {r_addr[15:1], cur_a0}
                     : (r_word && !r_second) ? r_wdata : {wbyte, wbyte};
  assign ctl_oe      = (state != S_HELD);
  assign addr_strobe = (state == S_ADDR) ? !cfg_valid_mode : (state != S_DATA);
  assign rd_n        = !((state == S_DATA) && !r_write);
  assign wr_lo_n     = !(wr_any && (!cfg_split_wr || !cur_a0));
  assign bhe_wrh_n   = cfg_split_wr ? !wr_hi
                     : !(in_cycle && (cur_a0 || (r_word && !r_second)));
  assign inst        = in_cycle && r_fetch && !r_write;
  assign hold_ack    = (state == S_HELD);
  assign bus_req     = hold_ack && req_valid;

  AST_WAIT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_DATA |-> wcnt <= cfg_wait_max); // R6
  AST_HOLD_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |-> (!ad_oe && !ctl_oe)); // R8
  AST_HOLD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_ack) |-> $past(state == S_IDLE)); // R8
  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cfg_hold_en) |-> !hold_ack); // R8
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (wr_lo_n && (!cfg_split_wr || bhe_wrh_n))); // R4
  AST_STROBE_DATA_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !addr_strobe); // R5
  AST_INST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    inst |-> wr_lo_n); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !req_done); // R12

endmodule

// File: tb/test_ext_bus_ctl.sv
module test_ext_bus_ctl;
  localparam int WW = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, req_valid, req_write, req_fetch, req_word, req_done;
  logic [15:0] req_addr, req_wdata, req_rdata, ad_in, ad_out;
  logic cfg_dyn_width, cfg_valid_mode, cfg_split_wr, cfg_hold_en;
  logic [WW-1:0] cfg_wait_max;
  logic bus_width_in, ready_in, ad_oe, ctl_oe, addr_strobe, rd_n, wr_lo_n, bhe_wrh_n;
  logic inst, hold_in, hold_ack, bus_req;

  ext_bus_ctl #(.WAIT_W(WW)) i_ext_bus_ctl (.*);

  int errs = 0, checks = 0;
  logic [7:0] mem [256];
  logic [7:0] lat = 8'h00;

  function automatic logic [7:0] fill(input int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  always_comb begin
    if (cfg_dyn_width && bus_width_in)
      ad_in = {mem[{lat[7:1], 1'b1}], mem[{lat[7:1], 1'b0}]};
    else
      ad_in = {8'hEE, mem[lat]};
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic mem_init();
    for (int i = 0; i < 256; i++) mem[i] = fill(i);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    #800000;
    errs++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  int nph, dcl0, dcl1, bs, bi, bw, br, bh;
  logic [15:0] pa0, pa1;
  logic pb0, pb1;

  task automatic run(input bit wr, input bit fe, input bit wd, input logic [15:0] a,
                     input logic [15:0] wdat, input int k, input bit hold_mid,
                     output logic [15:0] rd);
    int dcnt = 0;
    bit w16eff, aph, rph, wph, lo, hi;
    nph = 0; dcl0 = 0; dcl1 = 0; bs = 0; bi = 0; bw = 0; br = 0; bh = 0;
    rd = 16'h0;
    @(negedge clk);
    req_write = wr; req_fetch = fe; req_word = wd; req_addr = a; req_wdata = wdat;
    req_valid = 1'b1;
    for (int g = 0; g < 400; g++) begin
      @(negedge clk);
      w16eff = cfg_dyn_width && bus_width_in;
      aph = ad_oe && rd_n && wr_lo_n && (!cfg_split_wr || bhe_wrh_n);
      rph = !rd_n;
      wph = !wr_lo_n || (cfg_split_wr && !bhe_wrh_n);
      if (hold_ack || bus_req) bh++;
      if (aph) begin
        if (nph == 0) begin pa0 = ad_out; pb0 = bhe_wrh_n; end
        if (nph == 1) begin pa1 = ad_out; pb1 = bhe_wrh_n; end
        nph++;
        lat = ad_out[7:0];
        dcnt = 0;
        if (addr_strobe !== !cfg_valid_mode) bs++;
        if (inst !== (fe && !wr)) bi++;
        if (hold_mid) hold_in = 1'b1;
      end else if (rph || wph) begin
        ready_in = (dcnt >= k);
        dcnt++;
        if (nph == 1) dcl0++;
        if (nph == 2) dcl1++;
        if (addr_strobe !== 1'b0) bs++;
        if (inst !== (fe && !wr)) bi++;
        if ((rph && wr) || (wph && !wr) || (rph && wph)) br++;
        if (wr) begin
          if (cfg_split_wr) begin
            if (wr_lo_n !== !(!lat[0])) bw++;
            if (bhe_wrh_n !== !(lat[0] || (wd && nph == 1 && w16eff))) bw++;
          end else if (wr_lo_n !== 1'b0) bw++;
          lo = cfg_split_wr ? !wr_lo_n : !lat[0];
          hi = !bhe_wrh_n;
          if (w16eff) begin
            if (lo) mem[{lat[7:1], 1'b0}] = ad_out[7:0];
            if (hi) mem[{lat[7:1], 1'b1}] = ad_out[15:8];
          end else mem[lat] = ad_out[7:0];
        end
      end else ready_in = 1'b1;
      if (req_done) begin
        rd = req_rdata;
        if (addr_strobe !== 1'b1) bs++;
        req_valid = 1'b0;
        break;
      end
    end
    ready_in = 1'b1;
    @(negedge clk);
    chk("R12 done single pulse", int'(req_done), 0);
  endtask

  task automatic access(input bit wr, input bit fe, input bit wd, input logic [15:0] a,
                        input logic [15:0] wdat, input int k);
    logic [15:0] rd, ev;
    int expn, expd;
    mem_init();
    run(wr, fe, wd, a, wdat, k, 1'b0, rd);
    ev = {a[15:1], 1'b0};
    expn = (wd && !(cfg_dyn_width && bus_width_in)) ? 2 : 1;
    expd = 1 + ((k < int'(cfg_wait_max)) ? k : int'(cfg_wait_max));
    chk("R1 cycle count", nph, expn);
    chk("R3 first address", int'(pa0), int'(wd ? ev : a));
    if (expn == 2) chk("R3 second address", int'(pa1), int'(ev | 16'h1));
    if (!cfg_split_wr) begin
      chk("R2 byte-high enable", int'(pb0), (wd || a[0]) ? 0 : 1);
      if (expn == 2) chk("R2 byte-high enable 2nd", int'(pb1), 0);
    end
    chk("R6 data clocks", dcl0, expd);
    if (expn == 2) chk("R6 data clocks 2nd", dcl1, expd);
    chk("R5 strobe shape", bs, 0);
    chk("R7 fetch indicator", bi, 0);
    chk("R4 write strobes", bw + br, 0);
    chk("R8 no grant in cycle", bh, 0);
    if (!wr) begin
      if (wd) chk("R3 word read", int'(rd), int'({fill(ev + 1), fill(ev)}));
      else    chk("R11 byte read", int'(rd), int'(fill(a)));
    end else if (wd) begin
      chk("R4 word write low", int'(mem[ev[7:0]]), int'(wdat[7:0]));
      chk("R4 word write high", int'(mem[ev[7:0] + 8'd1]), int'(wdat[15:8]));
    end else begin
      chk("R11 byte write", int'(mem[a[7:0]]), int'(wdat[7:0]));
      chk("R2 neighbour untouched", int'(mem[a[7:0] ^ 8'd1]), int'(fill(a ^ 16'h1)));
    end
  endtask

  initial begin
    logic [15:0] rd;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_fetch = 1'b0; req_word = 1'b0;
    req_addr = '0; req_wdata = '0; cfg_dyn_width = 1'b0; cfg_valid_mode = 1'b0;
    cfg_split_wr = 1'b0; cfg_wait_max = 2'd2; cfg_hold_en = 1'b0; bus_width_in = 1'b0;
    ready_in = 1'b1; hold_in = 1'b0;
    mem_init();
    repeat (3) @(negedge clk);
    chk("R10 strobe high", int'(addr_strobe), 1);
    chk("R10 rd idle", int'(rd_n), 1);
    chk("R10 wr idle", int'(wr_lo_n & bhe_wrh_n), 1);
    chk("R10 bus off", int'(ad_oe | inst | hold_ack | req_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 strobe high idle", int'(addr_strobe), 1);

    for (int d = 0; d < 2; d++)
      for (int p = 0; p < 2; p++)
        for (int s = 0; s < 2; s++)
          for (int v = 0; v < 2; v++)
            for (int op = 0; op < 6; op++) begin
              logic [15:0] a;
              cfg_dyn_width = d[0]; bus_width_in = p[0];
              cfg_split_wr = s[0]; cfg_valid_mode = v[0];
              a = 16'h0020 + 16'(2 * (d * 8 + p * 4 + s * 2 + v)) + 16'((op == 1 || op == 4) ? 1 : 0);
              access(op >= 3, op != 1 && op < 3, op == 2 || op == 5, a,
                     16'hA55A ^ 16'(op * 16'h1111), (d + p + op) % 3);
            end

    cfg_dyn_width = 1'b1; bus_width_in = 1'b0; cfg_split_wr = 1'b0; cfg_valid_mode = 1'b1;
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 5; k++) begin
        cfg_wait_max = WW'(m);
        access(1'b0, 1'b0, 1'b1, 16'h0050, 16'h0, k);
      end
    cfg_wait_max = 2'd2;

    cfg_hold_en = 1'b0; hold_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 hold ignored when disabled", int'(hold_ack), 0);
    access(1'b0, 1'b1, 1'b0, 16'h0061, 16'h0, 0);
    hold_in = 1'b0;

    cfg_hold_en = 1'b1; hold_in = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R8 hold granted from idle", int'(hold_ack), 1);
    chk("R8 bus floated", int'(ad_oe | ctl_oe), 0);
    chk("R9 no bus request when idle", int'(bus_req), 0);
    req_write = 1'b0; req_fetch = 1'b0; req_word = 1'b0; req_addr = 16'h0070;
    req_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 bus request while held", int'(bus_req), 1);
    chk("R8 no cycle while held", int'(ad_oe), 0);
    hold_in = 1'b0;
    mem_init();
    run(1'b0, 1'b0, 1'b0, 16'h0070, 16'h0, 0, 1'b0, rd);
    chk("R8 request after release", int'(rd), int'(fill(16'h0070)));
    chk("R9 bus request dropped", int'(bus_req), 0);

    cfg_dyn_width = 1'b0;
    run(1'b0, 1'b0, 1'b1, 16'h0080, 16'h0, 1, 1'b1, rd);
    chk("R8 split pair kept whole", nph, 2);
    chk("R8 no grant mid request", bh, 0);
    chk("R3 word across hold", int'(rd), int'({fill(16'h81), fill(16'h80)}));
    @(negedge clk);
    chk("R8 grant after request", int'(hold_ack), 1);
    hold_in = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R8 released", int'(hold_ack), 0);

    summary();
    $finish;
  end
endmodule